// File: doc/BRIEF.md
# Input Offset Cancellation Loop Controller

This block closes the digital half of an input-offset cancellation loop. Every cycle of the fast detector clock it may receive an "increment" and/or a "decrement" vote. The votes come from edge samples that show a residual DC offset at the receiver input. The votes are summed over a fixed window of fast cycles. At the end of each window only the sign of the net sum is passed on, as a single up, down or hold step, to a wide accumulator that updates at the reduced window rate. The accumulator is wider than the DAC code, so it acts as the loop filter. Its top bits form the DAC code.

The code is expanded into a thermometer word with one line per DAC unit cell. Each cell steers its current to the positive cancellation leg when its line is high and to the negative leg when its line is low. The code therefore only ever moves the current one unit at a time and monotonically. The vote inputs carry no back-pressure: the block accepts a vote pair on every fast cycle, and no vote is ever refused or stalled.

Top module: `offset_cancel_ctrl`

## Requirements
- R1: While reset is low, and after it is released until the first window completes, the accumulator holds mid-scale (binary 1 followed by zeros), so the code is 32 and the 32 lowest thermometer lines are high.
- R2: A window of WIN_LEN fast cycles whose net vote count (increments minus decrements) is positive raises the accumulator by exactly one, however large the net count is.
- R3: A window with a net vote count of zero, including a window with no votes, leaves the accumulator unchanged.
- R4: A window with a negative net vote count lowers the accumulator by exactly one.
- R5: An increment and a decrement asserted in the same fast cycle cancel and contribute nothing to the window's net count.
- R6: At the top value (all ones) further upward steps leave it at the top; the code stays 63 and never wraps.
- R7: At zero further downward steps leave it at zero; the code stays 0 and never wraps.
- R8: The positive thermometer output has bit i high exactly when i is below the code, so its count of ones equals the code and a one-step code change toggles a single line. The negative output is the bitwise complement of the positive output.
- R9: Windows start on the first fast cycle after reset release and tile back to back. The code reflects a window two clock edges after the edge that samples that window's last vote.
- R10: The code is the top 6 bits of the 12-bit accumulator, so from mid-scale 63 upward steps keep the code at 32 and the 64th step makes it 33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast detector clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | 1 | Increment vote for this cycle |
| dec_i | input | 1 | Decrement vote for this cycle |
| code_o | output | 6 | Current DAC code |
| ios_p_o | output | 63 | Thermometer lines steering unit cells to the positive leg |
| ios_n_o | output | 63 | Complement lines steering unit cells to the negative leg |

## Verification
The sum-and-sign stage is tried with windows holding a single increment and with windows full of increments, which shows whether the vote magnitude leaks into the step size. Windows that are balanced, empty, or filled with simultaneous increment and decrement votes separate true cancellation from a stuck or biased counter. A run of 63 then 64 single-step windows shows whether the code is taken from the right accumulator slice. Long one-sided runs into both rails show whether the accumulator clamps or wraps. The thermometer and complement words are compared against the expected code after every window.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  typedef struct packed {
    logic  valid;
    step_e dir;
  } step_t;
endpackage

// File: rtl/ocl_vote_presum.sv
module ocl_vote_presum
  import ocl_pkg::*;
#(
  parameter int WIN_LEN = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_i,
  input  logic  dec_i,
  output step_t step_o
);
  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int SUM_W = $clog2(WIN_LEN + 1) + 1;

  logic [CNT_W-1:0]        wcnt;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sum_nx;
  logic signed [SUM_W-1:0] delta;
  logic                    win_end;

  // Simultaneous votes cancel (R5)
  always_comb begin
    unique case ({inc_i, dec_i})
      2'b10:   delta = SUM_W'(1);
      2'b01:   delta = -SUM_W'(1);
      default: delta = '0;
    endcase
  end

  assign sum_nx  = sum_q + delta;
  assign win_end = (wcnt == CNT_W'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt   <= '0;
      sum_q  <= '0;
      step_o <= '{valid: 1'b0, dir: STEP_HOLD};
    end else if (win_end) begin
      wcnt         <= '0;
      sum_q        <= '0;
      step_o.valid <= 1'b1;
      if (sum_nx > 0)      step_o.dir <= STEP_UP;
      else if (sum_nx < 0) step_o.dir <= STEP_DN;
      else                 step_o.dir <= STEP_HOLD;
    end else begin
      wcnt         <= wcnt + CNT_W'(1);
      sum_q        <= sum_nx;
      step_o.valid <= 1'b0;
    end
  end

  generate
    if (WIN_LEN > 1) begin : g_spacing
      // R9: one step strobe per window, never two in a row
      a_r9_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        step_o.valid |=> !step_o.valid);
    end
  endgenerate

  // R5: a cycle carrying both votes leaves the running sum unchanged
  a_r5_both_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i && !win_end) |=> (sum_q == $past(sum_q)));
endmodule

// File: rtl/ocl_slow_accum.sv
module ocl_slow_accum
  import ocl_pkg::*;
#(
  parameter int ACC_W  = 12,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc_q;
  logic             go_up;
  logic             go_dn;

  assign go_up = step_i.valid && (step_i.dir == STEP_UP) && (acc_q != ACC_MAX);
  assign go_dn = step_i.valid && (step_i.dir == STEP_DN) && (acc_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= ACC_MID;
    else if (go_up) acc_q <= acc_q + ACC_W'(1);
    else if (go_dn) acc_q <= acc_q - ACC_W'(1);
  end

  assign code_o = acc_q[ACC_W-1 -: CODE_W];

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i.valid && step_i.dir == STEP_UP && acc_q != ACC_MAX)
      |=> (acc_q == $past(acc_q) + ACC_W'(1)));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i.valid && step_i.dir == STEP_DN && acc_q != '0)
      |=> (acc_q == $past(acc_q) - ACC_W'(1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i.valid || step_i.dir == STEP_HOLD) |=> $stable(acc_q));

  a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == ACC_MAX && step_i.valid && step_i.dir == STEP_UP) |=> (acc_q == ACC_MAX));

  a_r7_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0 && step_i.valid && step_i.dir == STEP_DN) |=> (acc_q == '0));
endmodule

// File: rtl/ocl_therm_enc.sv
module ocl_therm_enc #(
  parameter int CODE_W = 6,
  localparam int LINES = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  therm_o
);
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign therm_o[i] = (code_i > CODE_W'(i));
    end
  endgenerate

  // R8: population of high lines tracks the code
  always_comb begin
    if (rst_n) a_r8_count: assert ($countones(therm_o) == int'(code_i));
  end

  // R8: a code change never toggles more than one line per cycle
  a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_o ^ $past(therm_o)) <= 1);
endmodule

// File: rtl/offset_cancel_ctrl.sv
module offset_cancel_ctrl
  import ocl_pkg::*;
#(
  parameter int WIN_LEN = 8,
  parameter int ACC_W   = 12,
  parameter int CODE_W  = 6,
  localparam int LINES  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [CODE_W-1:0] code_o,
  output logic [LINES-1:0]  ios_p_o,
  output logic [LINES-1:0]  ios_n_o
);
  step_t             step;
  logic [CODE_W-1:0] code;
  logic [LINES-1:0]  therm;

  ocl_vote_presum #(.WIN_LEN(WIN_LEN)) u_presum (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (inc_i),
    .dec_i  (dec_i),
    .step_o (step)
  );

  ocl_slow_accum #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step),
    .code_o (code)
  );

  ocl_therm_enc #(.CODE_W(CODE_W)) u_therm (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (code),
    .therm_o (therm)
  );

  assign code_o  = code;
  assign ios_p_o = therm;
  assign ios_n_o = ~therm;
endmodule

// File: tb/offset_cancel_ctrl_tb.sv
module offset_cancel_ctrl_tb;
  localparam int WIN    = 8;
  localparam int ACC_W  = 12;
  localparam int CODE_W = 6;
  localparam int LINES  = (1 << CODE_W) - 1;
  localparam int AMAX   = (1 << ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             inc_i = 1'b0;
  logic             dec_i = 1'b0;
  logic [CODE_W-1:0] code_o;
  logic [LINES-1:0]  ios_p_o;
  logic [LINES-1:0]  ios_n_o;

  int checks = 0;
  int errors = 0;
  int model_acc = 1 << (ACC_W - 1);
  int exp_q[$];
  string tag_q[$];
  bit released = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  offset_cancel_ctrl #(.WIN_LEN(WIN), .ACC_W(ACC_W), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i),
    .code_o(code_o), .ios_p_o(ios_p_o), .ios_n_o(ios_n_o)
  );

  function automatic logic [LINES-1:0] therm_of(input int c);
    logic [LINES-1:0] t;
    for (int i = 0; i < LINES; i++) t[i] = (i < c);
    return t;
  endfunction

  task automatic compare_all(input int exp_code, input string tag);
    checks++;
    if (int'(code_o) != exp_code) begin
      errors++;
      $display("FAIL %s code: actual %0d expected %0d", tag, code_o, exp_code);
    end
    checks++;
    if (ios_p_o !== therm_of(exp_code)) begin
      errors++;
      $display("FAIL R8 positive lines: actual %h expected %h", ios_p_o, therm_of(exp_code));
    end
    checks++;
    if (ios_n_o !== ~therm_of(exp_code)) begin
      errors++;
      $display("FAIL R8 negative lines: actual %h expected %h", ios_n_o, ~therm_of(exp_code));
    end
  endtask

  // Driver: one window of WIN cycles; both-votes first, then inc, then dec
  task automatic drive_win(input int n_both, input int n_inc, input int n_dec, input string tag);
    int net;
    for (int c = 0; c < WIN; c++) begin
      if (c > 0) @(negedge clk);
      if (c < n_both) begin
        inc_i = 1'b1; dec_i = 1'b1;
      end else if (c < n_both + n_inc) begin
        inc_i = 1'b1; dec_i = 1'b0;
      end else if (c < n_both + n_inc + n_dec) begin
        inc_i = 1'b0; dec_i = 1'b1;
      end else begin
        inc_i = 1'b0; dec_i = 1'b0;
      end
    end
    net = n_inc - n_dec;
    if (net > 0 && model_acc < AMAX) model_acc++;
    else if (net < 0 && model_acc > 0) model_acc--;
    exp_q.push_back(model_acc >> (ACC_W - CODE_W));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: window k is visible two negedges after its last vote (R9)
  initial begin
    int nn;
    wait (released);
    nn = 0;
    forever begin
      @(negedge clk);
      nn++;
      if (nn >= WIN + 1 && ((nn - (WIN + 1)) % WIN) == 0 && exp_q.size() > 0) begin
        compare_all(exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all(32, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    released = 1'b1;
    compare_all(32, "R1 after release");
    // R10 / R2: 63 single-vote up windows keep code 32, 64th with full votes gives 33
    for (int k = 0; k < 63; k++) drive_win(0, 1, 0, "R10 slice");
    drive_win(0, WIN, 0, "R2 magnitude ignored");
    // R3: balanced and empty windows
    drive_win(0, 4, 4, "R3 balanced");
    drive_win(0, 0, 0, "R3 empty");
    // R5: simultaneous votes cancel
    drive_win(WIN, 0, 0, "R5 all both");
    drive_win(WIN - 1, 0, 1, "R5 both plus dec");
    drive_win(WIN - 1, 1, 0, "R5 both plus inc");
    // R4: downward steps cross back below 33
    for (int k = 0; k < 70; k++) drive_win(0, 1, 3, "R4 down");
    // R6: run into the top rail and stay there
    for (int k = 0; k < 2200; k++) drive_win(0, WIN, 0, "R6 top rail");
    // R7: run into the bottom rail and stay there
    for (int k = 0; k < 4200; k++) drive_win(0, 0, WIN, "R7 bottom rail");
    drive_win(0, 2, 1, "R2 leave bottom");
    repeat (2 * WIN) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending results: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule